// File: doc/BRIEF.md
# Burst Address and Byte-Write Control

This block is the front end of a synchronous burst SRAM. It samples the address, chip enables, strobes and write controls on each rising clock edge and produces, one register stage later, the address the array should access, an active-high mask of the byte lanes to write, and a command code for the read pipeline.

A burst starts on either of two active-low address strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls. After the load, a 2-bit counter modifies only the two least significant address bits. It steps in linear or interleaved order, and only in cycles where the advance input is low. A new address can be loaded on any cycle, so bursts are optional. A strobe that arrives while the chip is not enabled ends the burst and issues a deselect command.

Top module: `sram_burst_front`

## Requirements
- R1: During and after reset, before any strobe, `cmd_o` is 2'b00 (idle), `arr_addr_o` is 0 and `wmask_o` is 0.
- R2: A strobe (`pstb_n` or `cstb_n` low) sampled while both `ce1_n` and `ce2_n` are low loads `addr_i`. After that edge, `arr_addr_o` equals the sampled `addr_i`. Within a burst only bits [1:0] change.
- R3: With `order_i` low at the load, each advance adds 1 modulo 4 to the starting 2-bit offset.
- R4: With `order_i` high at the load, the n-th advance gives the starting offset XOR (n mod 4).
- R5: In a cycle with no strobe and `adv_n` high, `arr_addr_o` does not change. During a burst the command repeats at the held address.
- R6: An enabled `pstb_n` strobe gives `cmd_o` = 2'b01 (read) and `wmask_o` = 0, even when the write controls are asserted. `pstb_n` takes priority over `cstb_n`.
- R7: With `gw_n` low, an enabled `cstb_n` strobe or a burst cycle gives `cmd_o` = 2'b10 (write) and sets all bits of `wmask_o`, whatever the values of `bwe_n` and `bsel_n`.
- R8: With `gw_n` high and `bwe_n` low, `wmask_o` bit i is set exactly when `bsel_n` bit i is low. `cmd_o` is write if any bit is set and read otherwise. With both `gw_n` and `bwe_n` high, the cycle is a read with an empty mask.
- R9: A strobe sampled while either chip enable is high gives `cmd_o` = 2'b11 (deselect) with `wmask_o` = 0, leaves `arr_addr_o` unchanged and ends the burst.
- R10: A new enabled strobe during a burst replaces the address and restarts the counter from the new low bits.
- R11: With no burst in progress and no strobe, `cmd_o` is idle and `wmask_o` is 0, whatever the values of `adv_n` and the write controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W | External address |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2_n | input | 1 | Chip enable 2, active low |
| pstb_n | input | 1 | Processor address strobe (read only), active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NBYTES | Per-lane byte selects, active low |
| arr_addr_o | output | ADDR_W | Array address |
| wmask_o | output | NBYTES | Byte-lane write mask, active high |
| cmd_o | output | 2 | 00 idle, 01 read, 10 write, 11 deselect |

## Verification
Every output is registered, so a wrong burst counter, latched order or base register shows on `arr_addr_o` in the cycle after the edge that sampled the cause. A wrong burst-active flag shows one cycle later: an idle code appears where a repeated read or write was expected, or the reverse. Bursts are walked through all four offsets in both orders from non-zero start values. This exposes wrap, sum and XOR errors by the second or third advance.

// File: rtl/sbf_pkg.sv
// Shared types for the burst address front end.
// Assumes: command codes are consumed by a read pipeline downstream.
package sbf_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_DESEL = 2'b11
    } sbf_cmd_e;
endpackage

// File: rtl/sbf_burst_ctr.sv
// Burst offset generator. Latches the start offset and order on load,
// then counts steps. Offset = start + steps (linear) or start ^ steps
// (interleaved). Assumes load has priority over step.
module sbf_burst_ctr #(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic             order_i,
    output logic [OFS_W-1:0] offset_o
);
    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] cnt_q;
    logic             order_q;

    // Hold start value, order and step count of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            order_q <= 1'b0;
        end else if (load_i) begin
            start_q <= start_i;
            cnt_q   <= '0;
            order_q <= order_i;
        end else if (step_i) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Combine start and count according to the latched order.
    always_comb begin
        if (order_q) offset_o = start_q ^ cnt_q;
        else         offset_o = start_q + cnt_q;
    end
endmodule

// File: rtl/sbf_wmask.sv
// Byte-lane write mask decode. Global write sets every lane; otherwise
// the byte-write enable gates the per-lane selects. All inputs active low,
// the mask active high. any_o flags a non-empty mask.
module sbf_wmask #(
    parameter int NBYTES = 2
) (
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] bsel_n,
    output logic [NBYTES-1:0] mask_o,
    output logic              any_o
);
    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_lane
            // One lane: global write, or byte enable with its select.
            assign mask_o[g] = !gw_n || (!bwe_n && !bsel_n[g]);
        end
    endgenerate

    // Any lane written means the cycle is a write.
    assign any_o = |mask_o;
endmodule

// File: rtl/sram_burst_front.sv
// Address and write-control front end of a burst SRAM. Samples strobes,
// enables, advance and write controls each edge and registers the array
// address, byte write mask and command. Assumes the two LSBs of the
// address are the burst field and that pstb_n outranks cstb_n.
module sram_burst_front #(
    parameter int ADDR_W = 19,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              order_i,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NBYTES-1:0] bsel_n,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [NBYTES-1:0] wmask_o,
    output logic [1:0]        cmd_o
);
    import sbf_pkg::*;

    localparam int OFS_W = 2;
    localparam int HI_W  = ADDR_W - OFS_W;

    logic              strobe, enabled, load, step;
    logic              active_q, nxt_active;
    logic [HI_W-1:0]   base_q;
    logic [OFS_W-1:0]  offset;
    logic [NBYTES-1:0] lane_mask, nxt_mask, wmask_q;
    logic              lane_any;
    sbf_cmd_e          nxt_cmd, cmd_q;

    sbf_wmask #(.NBYTES(NBYTES)) u_wmask (
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bsel_n (bsel_n),
        .mask_o (lane_mask),
        .any_o  (lane_any)
    );

    sbf_burst_ctr #(.OFS_W(OFS_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .start_i  (addr_i[OFS_W-1:0]),
        .order_i  (order_i),
        .offset_o (offset)
    );

    assign strobe  = !pstb_n || !cstb_n;
    assign enabled = !ce1_n && !ce2_n;

    // Decide the next command, mask and burst state from this cycle's inputs.
    always_comb begin
        nxt_cmd    = CMD_IDLE;
        nxt_mask   = '0;
        nxt_active = active_q;
        load       = 1'b0;
        step       = 1'b0;
        if (strobe) begin
            if (enabled) begin
                load       = 1'b1;
                nxt_active = 1'b1;
                if (pstb_n && lane_any) begin
                    nxt_cmd  = CMD_WRITE;
                    nxt_mask = lane_mask;
                end else begin
                    nxt_cmd  = CMD_READ;
                end
            end else begin
                nxt_cmd    = CMD_DESEL;
                nxt_active = 1'b0;
            end
        end else if (active_q) begin
            step = !adv_n;
            if (lane_any) begin
                nxt_cmd  = CMD_WRITE;
                nxt_mask = lane_mask;
            end else begin
                nxt_cmd  = CMD_READ;
            end
        end
    end

    // Register burst state, base address and the outgoing command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cmd_q    <= CMD_IDLE;
            wmask_q  <= '0;
        end else begin
            active_q <= nxt_active;
            cmd_q    <= nxt_cmd;
            wmask_q  <= nxt_mask;
            if (load) base_q <= addr_i[ADDR_W-1:OFS_W];
        end
    end

    assign arr_addr_o = {base_q, offset};
    assign wmask_o    = wmask_q;
    assign cmd_o      = cmd_q;
endmodule

// File: rtl/sbf_checker.sv
// Port-level properties of the burst front end, bound to its top module.
module sbf_checker #(
    parameter int ADDR_W = 19,
    parameter int NBYTES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              ce1_n,
    input logic              ce2_n,
    input logic              pstb_n,
    input logic              cstb_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic [ADDR_W-1:0] arr_addr_o,
    input logic [NBYTES-1:0] wmask_o,
    input logic [1:0]        cmd_o
);
    logic strobe_s, enabled_s;
    assign strobe_s  = !pstb_n || !cstb_n;
    assign enabled_s = !ce1_n && !ce2_n;

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_s && enabled_s) |=> (arr_addr_o == $past(addr_i)));

    assert_high_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_s |=> $stable(arr_addr_o[ADDR_W-1:2]));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_s && adv_n) |=> $stable(arr_addr_o));

    assert_pstb_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && enabled_s) |=> (cmd_o == 2'b01 && wmask_o == '0));

    assert_global_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb_n && !cstb_n && enabled_s && !gw_n) |=> (cmd_o == 2'b10 && wmask_o == '1));

    assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_s && !enabled_s) |=> (cmd_o == 2'b11 && wmask_o == '0 && $stable(arr_addr_o)));

    assert_mask_only_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 2'b10) |-> (wmask_o == '0));
endmodule

bind sram_burst_front sbf_checker #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_sbf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .ce1_n      (ce1_n),
    .ce2_n      (ce2_n),
    .pstb_n     (pstb_n),
    .cstb_n     (cstb_n),
    .adv_n      (adv_n),
    .gw_n       (gw_n),
    .arr_addr_o (arr_addr_o),
    .wmask_o    (wmask_o),
    .cmd_o      (cmd_o)
);

// File: tb/sram_burst_front_test.sv
module sram_burst_front_test;
    localparam int AW = 19;
    localparam int NB = 2;
    localparam logic [1:0] IDLE = 2'b00, RD = 2'b01, WR = 2'b10, DS = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          ce1_n, ce2_n, pstb_n, cstb_n, adv_n, order_i, gw_n, bwe_n;
    logic [NB-1:0] bsel_n;
    logic [AW-1:0] arr_addr_o;
    logic [NB-1:0] wmask_o;
    logic [1:0]    cmd_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sram_burst_front #(.ADDR_W(AW), .NBYTES(NB)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce1_n(ce1_n), .ce2_n(ce2_n),
        .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .order_i(order_i),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
        .arr_addr_o(arr_addr_o), .wmask_o(wmask_o), .cmd_o(cmd_o)
    );

    task automatic quiet();
        pstb_n = 1; cstb_n = 1; ce1_n = 0; ce2_n = 0; adv_n = 1;
        gw_n = 1; bwe_n = 1; bsel_n = '1;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [AW-1:0] ea, logic [1:0] ec, logic [NB-1:0] em);
        total++;
        if (arr_addr_o !== ea || cmd_o !== ec || wmask_o !== em) begin
            fails++;
            $display("FAIL %s: addr=%h cmd=%b mask=%b expected addr=%h cmd=%b mask=%b",
                     req, arr_addr_o, cmd_o, wmask_o, ea, ec, em);
        end
    endtask

    task automatic load(bit use_p, logic [AW-1:0] a, bit ord);
        quiet(); addr_i = a; order_i = ord;
        if (use_p) pstb_n = 0; else cstb_n = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; quiet(); addr_i = 19'h7ffff; order_i = 0;
        step(); step();
        chk("R1 in reset", '0, IDLE, '0);
        rst_n = 1; step();
        chk("R1 after reset", '0, IDLE, '0);
    endtask

    task automatic t_linear();
        logic [AW-1:0] a = 19'h5a5a6;
        load(0, a, 0); step();
        chk("R2 load", a, RD, '0);
        for (int n = 1; n <= 4; n++) begin
            quiet(); adv_n = 0; step();
            chk("R3 linear", {a[AW-1:2], 2'(a[1:0] + n)}, RD, '0);
        end
    endtask

    task automatic t_interleave();
        logic [AW-1:0] a = 19'h31235;
        load(1, a, 1); step();
        chk("R2 load interleaved", a, RD, '0);
        for (int n = 1; n <= 4; n++) begin
            quiet(); adv_n = 0; step();
            chk("R4 interleaved", {a[AW-1:2], a[1:0] ^ 2'(n)}, RD, '0);
        end
    endtask

    task automatic t_hold();
        logic [AW-1:0] a = 19'h00102;
        load(0, a, 0); step();
        quiet(); adv_n = 0; step();
        quiet(); step();
        chk("R5 hold no advance", 19'h00103, RD, '0);
        quiet(); step();
        chk("R5 hold second", 19'h00103, RD, '0);
        quiet(); adv_n = 0; step();
        chk("R5 resume", 19'h00100, RD, '0);
    endtask

    task automatic t_pstb_write();
        load(1, 19'h2222a, 0); gw_n = 0; bwe_n = 0; bsel_n = '0; step();
        chk("R6 pstb forces read", 19'h2222a, RD, '0);
        load(1, 19'h11111, 0); cstb_n = 0; gw_n = 0; step();
        chk("R6 pstb priority", 19'h11111, RD, '0);
    endtask

    task automatic t_global();
        load(0, 19'h44447, 0); gw_n = 0; bwe_n = 1; bsel_n = '1; step();
        chk("R7 global write", 19'h44447, WR, 2'b11);
        quiet(); adv_n = 0; gw_n = 0; bwe_n = 0; bsel_n = 2'b01; step();
        chk("R7 global in burst", 19'h44444, WR, 2'b11);
    endtask

    task automatic t_bytes();
        load(0, 19'h60001, 0); bwe_n = 0; bsel_n = 2'b10; step();
        chk("R8 lane 0", 19'h60001, WR, 2'b01);
        quiet(); adv_n = 0; bwe_n = 0; bsel_n = 2'b01; step();
        chk("R8 lane 1", 19'h60002, WR, 2'b10);
        quiet(); adv_n = 0; bwe_n = 1; bsel_n = 2'b00; step();
        chk("R8 no enable read", 19'h60003, RD, '0);
        quiet(); adv_n = 0; bwe_n = 0; bsel_n = 2'b11; step();
        chk("R8 no select read", 19'h60000, RD, '0);
    endtask

    task automatic t_desel();
        load(0, 19'h0abc1, 0); step();
        load(0, 19'h7fff0, 0); ce2_n = 1; step();
        chk("R9 deselect ce2", 19'h0abc1, DS, '0);
        quiet(); adv_n = 0; gw_n = 0; step();
        chk("R9 burst ended", 19'h0abc1, IDLE, '0);
        load(1, 19'h12340, 0); ce1_n = 1; step();
        chk("R9 deselect ce1", 19'h0abc1, DS, '0);
    endtask

    task automatic t_reload();
        load(0, 19'h33331, 1); step();
        quiet(); adv_n = 0; step();
        chk("R10 before reload", 19'h33330, RD, '0);
        load(0, 19'h55552, 0); adv_n = 0; step();
        chk("R10 reload", 19'h55552, RD, '0);
        quiet(); adv_n = 0; step();
        chk("R10 new order", 19'h55553, RD, '0);
    endtask

    task automatic t_idle();
        load(0, 19'h01010, 0); ce1_n = 1; step();
        quiet(); adv_n = 0; gw_n = 0; bwe_n = 0; bsel_n = '0; step();
        chk("R11 idle with write controls", 19'h01010 & 19'h0, IDLE, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        addr_i = '0; order_i = 0; rst_n = 0; quiet();
        t_reset();
        t_idle();
        t_linear();
        t_interleave();
        t_hold();
        t_pstb_write();
        t_global();
        t_bytes();
        t_desel();
        t_reload();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule